// File: doc/BRIEF.md
# Dual-Snapshot Register Rollback Controller

This block protects a processor's architectural register file against supply-voltage emergencies that are detected only after a fixed sensor delay. It mirrors every accepted register write into a live copy. At a fixed interval it copies that live copy into one of two snapshot banks, taking the two banks in turn. A snapshot taken after a fault but before the fault is reported may hold bad values. For that reason an emergency always rolls the register file back to the older of the two snapshots. The capture interval (21 cycles) is longer than the detection delay (20 cycles), so the older snapshot always predates the fault.

On an emergency the controller stalls and flushes the pipeline. It then streams the older snapshot back to the register file, four registers per beat, with the lowest indices first. The same beats also overwrite the live copy and the other bank, so both banks hold the restored state when the restore ends. Execution then resumes from that state, and the capture timer starts again from zero.

The register-write input and the restore output are both valid/ready streams. Write traffic is refused (ready low) for the whole restore, and the write source must hold its beat until it is accepted. The restore stream holds its beat, index and data stable while the consumer holds ready low. It moves to the next beat only on a cycle where valid and ready are both high.

Top module: `ckpt_rollback_ctrl`

## Requirements
- R1: After reset, no restore is in progress and the busy, stall, flush and restore-valid outputs are low with write-ready high. The live copy and both snapshot banks read as all zeros, so an emergency right after reset restores zeros to every register.
- R2: While no restore is in progress, the write input is ready. A write accepted at `wr_idx_i` updates that register in the live copy from the next cycle on.
- R3: Counting from reset release or from the end of a restore, a snapshot is captured on every INTERVAL-th cycle (cycles 21, 42, ... by default). It holds the writes accepted in earlier cycles, but not a write accepted in the capture cycle itself. Successive captures go to the two banks in turn, each time replacing the older bank.
- R4: An emergency accepted while idle restores the older snapshot, which is the one captured before the most recent capture. An emergency arriving in a capture cycle takes precedence, and that capture does not happen.
- R5: `flush_o` is a one-cycle pulse in the first restore cycle. `busy_o` is high for exactly the restore cycles. `stall_o` is high in the cycle an emergency is accepted and in every restore cycle.
- R6: A restore has NREG/PORTS beats (8 by default). Beat k presents registers PORTS*k+p on lane p, where lane p is bits [p*IW +: IW] of `rs_idx_o` and bits [p*DW +: DW] of `rs_data_o`, with IW = 5 and DW = 32 at the default parameters. Beats come in ascending order.
- R7: While `rs_valid_o` is high and `rs_ready_i` is low, the beat, its indices and its data stay unchanged. A beat advances only on a cycle with both signals high.
- R8: During a restore `wr_ready_o` is low. A write presented then is not accepted and never reaches the live copy or a later snapshot.
- R9: An emergency raised while a restore is running is ignored. The restore continues with the same source bank and ends after its normal beat count, and no second restore follows.
- R10: No snapshot is captured during a restore. When the restore ends, both banks hold the restored contents, so a further emergency before the next capture restores the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| emerg_i | input | 1 | Late-detected supply emergency flag |
| wr_valid_i | input | 1 | Register write offered |
| wr_ready_o | output | 1 | Register write accepted (low during restore) |
| wr_idx_i | input | IW (5) | Register index of the write |
| wr_data_i | input | DW (32) | Register value of the write |
| rs_valid_o | output | 1 | Restore beat valid |
| rs_ready_i | input | 1 | Register file accepts the restore beat |
| rs_idx_o | output | PORTS*IW (20) | Register index per restore lane |
| rs_data_o | output | PORTS*DW (128) | Register value per restore lane |
| stall_o | output | 1 | Pipeline stall request |
| flush_o | output | 1 | One-cycle pipeline flush request |
| busy_o | output | 1 | Restore in progress |

## Verification
The assertions assume that INTERVAL is at least 2 and that PORTS divides NREG into at least two beats. They also assume that every input is a known value from reset release onward. The emergency flag may arrive in any cycle, including during a restore or on a capture cycle, and the restore consumer may drop ready in any pattern. The bench drives all inputs away from the clock edge with defined values and holds them for whole cycles. Its stimulus holds emergencies for several cycles inside a restore, drops ready periodically, and offers writes while the write port is blocked.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic {
    RB_IDLE = 1'b0,
    RB_RUN  = 1'b1
  } rb_state_e;

  localparam int RB_NREG     = 32;
  localparam int RB_DW       = 32;
  localparam int RB_PORTS    = 4;
  localparam int RB_INTERVAL = 21;
  localparam int RB_DETECT   = 20;
endpackage

// File: rtl/rb_ckpt_timer.sv
module rb_ckpt_timer #(
  parameter int INTERVAL = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic capture
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (hold)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign capture = !hold && (cnt_q == LAST);

  AST_CAPTURE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture); // R3
endmodule

// File: rtl/rb_ckpt_store.sv
module rb_ckpt_store #(
  parameter int NREG  = 32,
  parameter int DW    = 32,
  parameter int PORTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  live_we,
  input  logic [$clog2(NREG)-1:0] live_idx,
  input  logic [DW-1:0]         live_data,
  input  logic                  cap_en,
  input  logic                  rs_we,
  input  logic [$clog2(NREG/PORTS)-1:0] rs_beat,
  input  logic                  rs_src,
  output logic                  older,
  output logic [PORTS*DW-1:0]   rd_data
);
  localparam int IW = $clog2(NREG);

  logic [DW-1:0] live_q [NREG];
  logic [DW-1:0] bank_q [2][NREG];
  logic          older_q;
  logic [IW-1:0] lane_ix [PORTS];

  for (genvar p = 0; p < PORTS; p++) begin : g_lane
    assign lane_ix[p] = IW'(rs_beat) * IW'(PORTS) + IW'(p);
    assign rd_data[p*DW +: DW] = bank_q[rs_src][lane_ix[p]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        live_q[i]    <= '0;
        bank_q[0][i] <= '0;
        bank_q[1][i] <= '0;
      end
      older_q <= 1'b0;
    end else begin
      if (cap_en) begin
        for (int i = 0; i < NREG; i++) bank_q[older_q][i] <= live_q[i];
        older_q <= ~older_q;
      end
      if (live_we) live_q[live_idx] <= live_data;
      if (rs_we) begin
        for (int p = 0; p < PORTS; p++) begin
          live_q[lane_ix[p]]          <= bank_q[rs_src][lane_ix[p]];
          bank_q[~rs_src][lane_ix[p]] <= bank_q[rs_src][lane_ix[p]];
        end
      end
    end
  end

  assign older = older_q;

  AST_NO_LIVE_WRITE_IN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rs_we |-> !live_we); // R8
  AST_NO_CAPTURE_IN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rs_we |-> !cap_en); // R10
endmodule

// File: rtl/rb_restore_seq.sv
module rb_restore_seq import rb_pkg::*; #(
  parameter int BEATS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     emerg,
  input  logic                     rs_ready,
  input  logic                     older,
  output logic                     busy,
  output logic                     start,
  output logic                     rs_valid,
  output logic                     rs_we,
  output logic [$clog2(BEATS)-1:0] beat,
  output logic                     src,
  output logic                     flush
);
  localparam int BW = $clog2(BEATS);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  rb_state_e     st_q;
  logic [BW-1:0] beat_q;
  logic          src_q;
  logic          flush_q;
  logic          last_fire;

  assign busy      = (st_q == RB_RUN);
  assign start     = emerg && (st_q == RB_IDLE);
  assign rs_valid  = busy;
  assign rs_we     = rs_valid && rs_ready;
  assign last_fire = rs_we && (beat_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RB_IDLE;
      beat_q  <= '0;
      src_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= start;
      if (start) begin
        st_q   <= RB_RUN;
        beat_q <= '0;
        src_q  <= older;
      end else if (rs_we) begin
        if (last_fire) begin
          st_q   <= RB_IDLE;
          beat_q <= '0;
        end else begin
          beat_q <= beat_q + 1'b1;
        end
      end
    end
  end

  assign beat  = beat_q;
  assign src   = src_q;
  assign flush = flush_q;

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(beat_q) && $stable(src_q))); // R7
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush); // R5
  AST_FLUSH_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (busy && beat_q == '0)); // R5
  AST_EMERG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && emerg && !last_fire) |=> (busy && $stable(src_q))); // R9
  AST_START_LOW_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (beat_q == '0)); // R6
endmodule

// File: rtl/ckpt_rollback_ctrl.sv
module ckpt_rollback_ctrl import rb_pkg::*; #(
  parameter int NREG         = RB_NREG,
  parameter int DW           = RB_DW,
  parameter int PORTS        = RB_PORTS,
  parameter int INTERVAL     = RB_INTERVAL,
  parameter int DETECT_DELAY = RB_DETECT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        emerg_i,
  input  logic                        wr_valid_i,
  output logic                        wr_ready_o,
  input  logic [$clog2(NREG)-1:0]     wr_idx_i,
  input  logic [DW-1:0]               wr_data_i,
  output logic                        rs_valid_o,
  input  logic                        rs_ready_i,
  output logic [PORTS*$clog2(NREG)-1:0] rs_idx_o,
  output logic [PORTS*DW-1:0]         rs_data_o,
  output logic                        stall_o,
  output logic                        flush_o,
  output logic                        busy_o
);
  localparam int IW    = $clog2(NREG);
  localparam int BEATS = NREG / PORTS;
  localparam int BW    = $clog2(BEATS);

  if (INTERVAL <= DETECT_DELAY) begin : g_bad_interval
    $error("capture interval must exceed the detection delay");
  end

  logic          busy, start, rs_we, src, older, capture, live_we;
  logic [BW-1:0] beat;

  assign wr_ready_o = !busy;
  assign live_we    = wr_valid_i && wr_ready_o;

  rb_ckpt_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (busy || start),
    .capture (capture)
  );

  rb_restore_seq #(.BEATS(BEATS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .emerg    (emerg_i),
    .rs_ready (rs_ready_i),
    .older    (older),
    .busy     (busy),
    .start    (start),
    .rs_valid (rs_valid_o),
    .rs_we    (rs_we),
    .beat     (beat),
    .src      (src),
    .flush    (flush_o)
  );

  rb_ckpt_store #(.NREG(NREG), .DW(DW), .PORTS(PORTS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_we   (live_we),
    .live_idx  (wr_idx_i),
    .live_data (wr_data_i),
    .cap_en    (capture),
    .rs_we     (rs_we),
    .rs_beat   (beat),
    .rs_src    (src),
    .older     (older),
    .rd_data   (rs_data_o)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_idx
    assign rs_idx_o[p*IW +: IW] = IW'(beat) * IW'(PORTS) + IW'(p);
  end

  assign busy_o  = busy;
  assign stall_o = busy || start;

  AST_STALL_COVERS_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid_o |-> (stall_o && busy_o)); // R5
  AST_CAPTURE_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (!busy_o && !emerg_i)); // R4
endmodule

// File: tb/ckpt_rollback_ctrl_bench.sv
module ckpt_rollback_ctrl_bench;
  localparam int NREG = 32, DW = 32, PORTS = 4, IW = 5, BEATS = 8, INTERVAL = 21;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, emerg_i, wr_valid_i, wr_ready_o, rs_valid_o, rs_ready_i;
  logic stall_o, flush_o, busy_o;
  logic [IW-1:0] wr_idx_i;
  logic [DW-1:0] wr_data_i;
  logic [PORTS*IW-1:0] rs_idx_o;
  logic [PORTS*DW-1:0] rs_data_o;

  ckpt_rollback_ctrl u_ckpt_rollback_ctrl (
    .clk(clk), .rst_n(rst_n), .emerg_i(emerg_i),
    .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rs_valid_o(rs_valid_o), .rs_ready_i(rs_ready_i), .rs_idx_o(rs_idx_o), .rs_data_o(rs_data_o),
    .stall_o(stall_o), .flush_o(flush_o), .busy_o(busy_o)
  );

  int n_chk = 0, n_err = 0;

  // reference state derived from the requirements
  logic [DW-1:0] m_live [NREG];
  logic [DW-1:0] m_bank [2][NREG];
  bit m_old, m_busy, m_src, m_flush;
  int m_cnt, m_beat;

  // stimulus table: {emergency, write index, write data, idle cycles after}
  localparam int NT = 10;
  localparam logic [45:0] TBL [NT] = '{
    {1'b0, 5'd3,  32'hA1A1_0001, 8'd2},
    {1'b0, 5'd31, 32'hB2B2_0002, 8'd5},
    {1'b0, 5'd0,  32'hC3C3_0003, 8'd15},
    {1'b0, 5'd3,  32'hD4D4_0004, 8'd25},
    {1'b1, 5'd7,  32'hE5E5_0005, 8'd12},
    {1'b0, 5'd7,  32'hF6F6_0006, 8'd30},
    {1'b0, 5'd12, 32'h7777_0007, 8'd30},
    {1'b1, 5'd12, 32'h8888_0008, 8'd12},
    {1'b0, 5'd5,  32'h9999_0009, 8'd3},
    {1'b1, 5'd5,  32'hAAAA_000A, 8'd12}
  };

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) begin
      m_live[i] = '0; m_bank[0][i] = '0; m_bank[1][i] = '0;
    end
    m_old = 0; m_busy = 0; m_src = 0; m_flush = 0; m_cnt = 0; m_beat = 0;
  endtask

  task automatic model_step(input logic wv, input logic [IW-1:0] wi, input logic [DW-1:0] wd,
                            input logic em, input logic rr);
    m_flush = 0;
    if (m_busy) begin
      if (rr) begin
        for (int p = 0; p < PORTS; p++) begin
          m_live[m_beat*PORTS+p] = m_bank[m_src][m_beat*PORTS+p];
          m_bank[m_src ? 0 : 1][m_beat*PORTS+p] = m_bank[m_src][m_beat*PORTS+p];
        end
        m_beat++;
        if (m_beat == BEATS) begin m_busy = 0; m_beat = 0; end
      end
      m_cnt = 0;
    end else if (em) begin
      m_busy = 1; m_beat = 0; m_src = m_old; m_flush = 1; m_cnt = 0;
      if (wv) m_live[wi] = wd;
    end else begin
      if (m_cnt == INTERVAL - 1) begin
        for (int i = 0; i < NREG; i++) m_bank[m_old][i] = m_live[i];
        m_old = !m_old; m_cnt = 0;
      end else m_cnt++;
      if (wv) m_live[wi] = wd;
    end
  endtask

  task automatic cyc(input logic wv, input logic [IW-1:0] wi, input logic [DW-1:0] wd,
                     input logic em, input logic rr, input string tag);
    wr_valid_i = wv; wr_idx_i = wi; wr_data_i = wd; emerg_i = em; rs_ready_i = rr;
    #1;
    chk("R5", "busy", busy_o, m_busy);
    chk("R8", "wr_ready", wr_ready_o, !m_busy);
    chk("R5", "stall", stall_o, m_busy | (em & !m_busy));
    chk("R5", "flush", flush_o, m_flush);
    chk("R6", "rs_valid", rs_valid_o, m_busy);
    if (m_busy) begin
      for (int p = 0; p < PORTS; p++) begin
        chk("R6", "rs_idx", rs_idx_o[p*IW +: IW], m_beat*PORTS + p);
        chk(tag, "rs_data", rs_data_o[p*DW +: DW], m_bank[m_src][m_beat*PORTS+p]);
      end
    end
    @(posedge clk);
    model_step(wv, wi, wd, em, rr);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b0, '0, '0, 1'b0, 1'b1, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_valid_i = 0; wr_idx_i = '0; wr_data_i = '0; emerg_i = 0; rs_ready_i = 1;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    #1;
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "stall after reset", stall_o, 0);
    chk("R1", "flush after reset", flush_o, 0);
    chk("R1", "rs_valid after reset", rs_valid_o, 0);
    chk("R1", "wr_ready after reset", wr_ready_o, 1);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1: emergency straight after reset restores all zeros
    cyc(1'b1, 5'd1, 32'h1111_1111, 1'b1, 1'b1, "R1");
    idle(10, "R1");

    // table walk: writes, captures and emergencies (R2 R3 R4)
    for (int k = 0; k < NT; k++) begin
      cyc(1'b1, TBL[k][44:40], TBL[k][39:8], TBL[k][45], 1'b1, "R2 R3 R4");
      idle(int'(TBL[k][7:0]), "R2 R3 R4");
    end

    // R7: restore consumer drops ready periodically
    cyc(1'b1, 5'd17, 32'h0BAD_F00D, 1'b0, 1'b1, "R7");
    idle(45, "R7");
    cyc(1'b0, '0, '0, 1'b1, 1'b1, "R7");
    for (int k = 0; k < 20; k++) cyc(1'b0, '0, '0, 1'b0, (k % 3) != 0, "R7");
    idle(3, "R7");

    // R9: emergency held high through most of a restore
    cyc(1'b0, '0, '0, 1'b1, 1'b1, "R9");
    for (int k = 0; k < 6; k++) cyc(1'b0, '0, '0, 1'b1, 1'b1, "R9");
    idle(6, "R9");
    chk("R9", "no second restore", busy_o, 0);

    // R8: writes offered during a restore are refused and never captured
    cyc(1'b1, 5'd9, 32'h0000_1234, 1'b0, 1'b1, "R8");
    idle(44, "R8");
    cyc(1'b0, '0, '0, 1'b1, 1'b1, "R8");
    for (int k = 0; k < 8; k++) cyc(1'b1, 5'd9, 32'hDEAD_0000 + k, 1'b0, 1'b1, "R8");
    idle(50, "R8");
    cyc(1'b0, '0, '0, 1'b1, 1'b1, "R8");
    idle(10, "R8");

    // R10: emergency right after restore, then one at the timer boundary
    cyc(1'b1, 5'd20, 32'h2020_2020, 1'b1, 1'b1, "R10");
    idle(8, "R10");
    cyc(1'b0, '0, '0, 1'b1, 1'b1, "R10");
    idle(8, "R10");
    cyc(1'b1, 5'd21, 32'h2121_2121, 1'b0, 1'b1, "R10");
    idle(INTERVAL - 2, "R10");
    cyc(1'b1, 5'd22, 32'h2222_2222, 1'b0, 1'b1, "R3");
    cyc(1'b0, '0, '0, 1'b1, 1'b1, "R4");
    idle(10, "R10");
    chk("R10", "idle after restore", busy_o, 0);

    // R1: reset in mid-run clears every snapshot
    cyc(1'b1, 5'd4, 32'h4444_4444, 1'b0, 1'b1, "R1");
    idle(30, "R1");
    do_reset();
    cyc(1'b0, '0, '0, 1'b1, 1'b1, "R1");
    idle(10, "R1");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule